// File: doc/BRIEF.md
# Six-Decade Predetermining BCD Up/Down Counter

This block is a synchronous counter of six binary-coded decimal digits. It steps once for each clock cycle in which its count enable is high, either upward or downward. Three internal target registers sit beside the count, and each holds six BCD digits. The start register supplies the value for a load. The early-warning register drives a match flag only. The terminal register marks the point where an upward count folds back to zero.

The counter reloads itself. When a step comes in up mode while the count equals the terminal value, the count goes to zero instead of incrementing. When a step comes in down mode while the count is zero, the count takes the start value instead of borrowing to 999999. A separate input can suppress either reload.

Software or a thumbwheel scanner fills the registers one digit per cycle. Each write carries a 2-bit register code, a 3-bit digit position and a 4-bit BCD nibble. Three flags report, in the same cycle, when the count is zero, when it equals the early-warning value and when it equals the terminal value.

Top module: `bcd_predet_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count and all digits of all three registers become zero. The count therefore reads 000000 with all three flags high.
- R2: In up mode (`count_up`=1), a step adds one in BCD. A digit at 9 goes to 0 and carries into the next digit. Every nibble of `count` always stays in 0..9. The count 999999 steps to 000000 when the automatic clear is suppressed.
- R3: In down mode (`count_up`=0), a step subtracts one in BCD. A digit at 0 goes to 9 and borrows from the next digit.
- R4: The count stays unchanged when `count_en` is low. It also stays unchanged when `count_hold` is high, and hold outranks both stepping and the automatic reloads.
- R5: When `clear` is high, the next count is 000000. Clear outranks load, hold and stepping.
- R6: When `load_preset` is high and `clear` is low, the next count equals the start register. The load outranks hold and stepping.
- R7: A step in up mode while the count equals the terminal register gives 000000. When `no_auto_clear` is high, the counter increments normally instead.
- R8: A step in down mode while the count is 000000 gives the start register value. When `no_auto_load` is high, the count goes to 999999 instead.
- R9: When `st_wr` is high, `st_data` is written into digit `st_idx` of a register, where digit 0 is bits [3:0] and is the least significant digit. The register depends on `st_sel`: 00 writes nothing, 01 writes early-warning, 10 writes terminal and 11 writes start. Register writes proceed in parallel with counting.
- R10: A write with `st_data` above 9 or with `st_idx` above 5 leaves every register unchanged.
- R11: `zero_flag`, `warn_flag` and `term_flag` are combinational. Each is high exactly when the present count equals zero, the early-warning register or the terminal register, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Step the counter this cycle |
| count_hold | input | 1 | Freeze the count |
| count_up | input | 1 | 1 = count up, 0 = count down |
| clear | input | 1 | Force the count to zero |
| load_preset | input | 1 | Load the count from the start register |
| no_auto_clear | input | 1 | Suppress the up-mode fold to zero |
| no_auto_load | input | 1 | Suppress the down-mode reload at zero |
| st_wr | input | 1 | Register digit write strobe |
| st_sel | input | 2 | Register code: 00 none, 01 early-warning, 10 terminal, 11 start |
| st_idx | input | 3 | Digit position, 0 = least significant |
| st_data | input | 4 | BCD nibble to write |
| count | output | 24 | Present count, six BCD digits |
| zero_flag | output | 1 | Count is zero |
| warn_flag | output | 1 | Count equals the early-warning register |
| term_flag | output | 1 | Count equals the terminal register |

## Verification
An up run against a small terminal value shows the automatic clear, because the count folds at the terminal value rather than at 999999. A down run from a loaded start value shows the automatic reload at zero. Repeating both runs with the reloads suppressed separates them from plain wrapping. Runs that load 999990 and nearby values drive carries and borrows through several digits at once. Stacked control inputs (clear with load, load with hold, hold with a reload pending) separate the priority order. Writes with out-of-range nibbles, indices and the idle register code are followed by a load, which makes any leak visible on `count`. A long pseudo-random phase mixes all inputs against the reference model.

// File: rtl/bcd_predet_pkg.sv
// Package: shared definitions for the predetermining BCD counter.
// Assumes: the register code values are fixed by the write interface.
package bcd_predet_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_WARN  = 2'b01,
        SEL_TERM  = 2'b10,
        SEL_START = 2'b11
    } store_sel_e;

    localparam int NUM_STORES = 3;
    localparam logic [3:0] BCD_MAX = 4'd9;

    // Maps a register slot number to its write code.
    function automatic store_sel_e slot_code(input int slot);
        case (slot)
            0:       return SEL_WARN;
            1:       return SEL_TERM;
            default: return SEL_START;
        endcase
    endfunction

endpackage

// File: rtl/bcd_step_cell.sv
// Module: one BCD decade of the step chain.
// Computes the decade's next value for an increment or decrement.
// Assumes: cur is a valid BCD digit; cin high means the lower decades roll over.
module bcd_step_cell
    import bcd_predet_pkg::*;
(
    input  logic [3:0] cur,
    input  logic       up,
    input  logic       cin,
    output logic [3:0] nxt,
    output logic       cout
);

    // Next digit and carry/borrow out for one decade.
    always_comb begin
        nxt  = cur;
        cout = 1'b0;
        if (cin) begin
            if (up) begin
                if (cur >= BCD_MAX) begin
                    nxt  = 4'd0;
                    cout = 1'b1;
                end else begin
                    nxt = cur + 4'd1;
                end
            end else begin
                if (cur == 4'd0) begin
                    nxt  = BCD_MAX;
                    cout = 1'b1;
                end else begin
                    nxt = cur - 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/bcd_store_bank.sv
// Module: the three digit-addressable BCD target registers.
// A write lands in one digit of one register. Writes with an idle code,
// a non-BCD nibble or an index past the last digit are dropped.
// Assumes: synchronous active-low reset clears every digit.
module bcd_store_bank
    import bcd_predet_pkg::*;
#(
    parameter  int DIGITS = 6,
    localparam int W      = 4 * DIGITS,
    localparam int IDXW   = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      sel,
    input  logic [IDXW-1:0] idx,
    input  logic [3:0]      data,
    output logic [W-1:0]    warn_q,
    output logic [W-1:0]    term_q,
    output logic [W-1:0]    start_q
);

    logic       wr_ok;
    store_sel_e sel_e;

    // Qualifies a write: BCD nibble and an index inside the register.
    always_comb begin
        sel_e = store_sel_e'(sel);
        wr_ok = wr && (data <= BCD_MAX) && (int'(idx) < DIGITS);
    end

    logic [NUM_STORES-1:0][W-1:0] regs;

    for (genvar s = 0; s < NUM_STORES; s++) begin : g_store
        localparam store_sel_e CODE = slot_code(s);
        // Writes the addressed digit of this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[s] <= '0;
            end else if (wr_ok && (sel_e == CODE)) begin
                for (int d = 0; d < DIGITS; d++) begin
                    if (int'(idx) == d) regs[s][4*d +: 4] <= data;
                end
            end
        end
    end

    assign warn_q  = regs[0];
    assign term_q  = regs[1];
    assign start_q = regs[2];

endmodule

// File: rtl/bcd_match.sv
// Module: equality comparators between the count and the targets.
// Assumes: all inputs are full-width BCD words.
module bcd_match #(
    parameter  int DIGITS = 6,
    localparam int W      = 4 * DIGITS
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] warn_v,
    input  logic [W-1:0] term_v,
    output logic         is_zero,
    output logic         is_warn,
    output logic         is_term
);

    // Three parallel equality tests.
    always_comb begin
        is_zero = (cnt == '0);
        is_warn = (cnt == warn_v);
        is_term = (cnt == term_v);
    end

endmodule

// File: rtl/bcd_predet_counter.sv
// Module: six-decade predetermining BCD up/down counter (top).
// Priority per cycle: reset, clear, load, hold, automatic reload, step.
// The chain's top borrow shows a down step from zero; the terminal
// comparator drives the up-mode fold to zero.
// Assumes: one step per clock with count_en high; all inputs synchronous.
module bcd_predet_counter
    import bcd_predet_pkg::*;
#(
    parameter  int DIGITS = 6,
    localparam int W      = 4 * DIGITS,
    localparam int IDXW   = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            count_en,
    input  logic            count_hold,
    input  logic            count_up,
    input  logic            clear,
    input  logic            load_preset,
    input  logic            no_auto_clear,
    input  logic            no_auto_load,
    input  logic            st_wr,
    input  logic [1:0]      st_sel,
    input  logic [IDXW-1:0] st_idx,
    input  logic [3:0]      st_data,
    output logic [W-1:0]    count,
    output logic            zero_flag,
    output logic            warn_flag,
    output logic            term_flag
);

    logic [W-1:0]    count_q;
    logic [W-1:0]    count_d;
    logic [W-1:0]    stepped;
    logic [DIGITS:0] carry;
    logic [W-1:0]    warn_q;
    logic [W-1:0]    term_q;
    logic [W-1:0]    start_q;
    logic            hit_term;
    logic            at_floor;

    bcd_store_bank #(.DIGITS(DIGITS)) u_stores (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (st_wr),
        .sel     (st_sel),
        .idx     (st_idx),
        .data    (st_data),
        .warn_q  (warn_q),
        .term_q  (term_q),
        .start_q (start_q)
    );

    assign carry[0] = 1'b1;

    for (genvar d = 0; d < DIGITS; d++) begin : g_dec
        bcd_step_cell u_cell (
            .cur  (count_q[4*d +: 4]),
            .up   (count_up),
            .cin  (carry[d]),
            .nxt  (stepped[4*d +: 4]),
            .cout (carry[d+1])
        );
    end

    bcd_match #(.DIGITS(DIGITS)) u_match (
        .cnt     (count_q),
        .warn_v  (warn_q),
        .term_v  (term_q),
        .is_zero (zero_flag),
        .is_warn (warn_flag),
        .is_term (term_flag)
    );

    // Reload conditions: terminal reached going up, floor reached going down.
    always_comb begin
        hit_term = count_up && term_flag && !no_auto_clear;
        at_floor = !count_up && carry[DIGITS] && !no_auto_load;
    end

    // Next-count selection in priority order.
    always_comb begin
        if (clear)                      count_d = '0;
        else if (load_preset)           count_d = start_q;
        else if (count_hold || !count_en) count_d = count_q;
        else if (hit_term)              count_d = '0;
        else if (at_floor)              count_d = start_q;
        else                            count_d = stepped;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/bcd_predet_counter_chk.sv
// Module: property checker for the predetermining counter, bound to the top.
// Assumes: it sees the start and terminal registers through the bind.
module bcd_predet_counter_chk #(
    parameter  int DIGITS = 6,
    localparam int W      = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         count_en,
    input logic         count_hold,
    input logic         count_up,
    input logic         clear,
    input logic         load_preset,
    input logic         no_auto_clear,
    input logic         no_auto_load,
    input logic [W-1:0] count,
    input logic [W-1:0] start_val,
    input logic [W-1:0] term_val
);

    // Every nibble of a word is a BCD digit.
    function automatic logic all_bcd(input logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int d = 0; d < DIGITS; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // R2
    bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_bcd(count));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R6
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_preset) |=> (count == $past(start_val)));

    // R4
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_preset && (count_hold || !count_en)) |=> $stable(count));

    // R7
    fold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_preset && !count_hold && count_en && count_up &&
         !no_auto_clear && (count == term_val)) |=> (count == '0));

    // R8
    floor_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_preset && !count_hold && count_en && !count_up &&
         !no_auto_load && (count == '0)) |=> (count == $past(start_val)));

endmodule

bind bcd_predet_counter bcd_predet_counter_chk #(.DIGITS(DIGITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_en      (count_en),
    .count_hold    (count_hold),
    .count_up      (count_up),
    .clear         (clear),
    .load_preset   (load_preset),
    .no_auto_clear (no_auto_clear),
    .no_auto_load  (no_auto_load),
    .count         (count),
    .start_val     (start_q),
    .term_val      (term_q)
);

// File: tb/bcd_predet_counter_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module bcd_predet_counter_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        en = 0, hold = 0, up = 1, clr = 0, ld = 0, nac = 0, nal = 0, wr = 0;
    logic [1:0]  sel = 0;
    logic [2:0]  idx = 0;
    logic [3:0]  dat = 0;
    logic [23:0] count;
    logic        zero_flag, warn_flag, term_flag;

    bcd_predet_counter u_bcd_predet_counter (
        .clk(clk), .rst_n(rst_n), .count_en(en), .count_hold(hold),
        .count_up(up), .clear(clr), .load_preset(ld),
        .no_auto_clear(nac), .no_auto_load(nal), .st_wr(wr),
        .st_sel(sel), .st_idx(idx), .st_data(dat), .count(count),
        .zero_flag(zero_flag), .warn_flag(warn_flag), .term_flag(term_flag)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string tag      = "R1";

    int m_cnt = 0;
    int m_warn[6];
    int m_term[6];
    int m_start[6];

    function automatic int dec_val(input int a[6]);
        int v = 0;
        for (int d = 5; d >= 0; d--) v = v * 10 + a[d];
        return v;
    endfunction

    function automatic logic [23:0] to_bcd(input int v);
        logic [23:0] r = '0;
        for (int d = 0; d < 6; d++) begin
            r[4*d +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check_bit(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One clock: predict, step, compare.
    task automatic cyc();
        int nc;
        int sv, tv, wv;
        sv = dec_val(m_start);
        tv = dec_val(m_term);
        nc = m_cnt;
        if (!rst_n) begin
            nc = 0;
            for (int d = 0; d < 6; d++) begin
                m_warn[d] = 0; m_term[d] = 0; m_start[d] = 0;
            end
        end else begin
            if (clr)                nc = 0;
            else if (ld)            nc = sv;
            else if (hold || !en)   nc = m_cnt;
            else if (up)            nc = (m_cnt == tv && !nac) ? 0 : (m_cnt + 1) % 1000000;
            else                    nc = (m_cnt == 0 && !nal) ? sv : (m_cnt + 999999) % 1000000;
            if (wr && dat <= 9 && idx < 6) begin
                case (sel)
                    2'b01: m_warn[idx]  = int'(dat);
                    2'b10: m_term[idx]  = int'(dat);
                    2'b11: m_start[idx] = int'(dat);
                    default: ;
                endcase
            end
        end
        m_cnt = nc;
        @(posedge clk);
        #1;
        wv = dec_val(m_warn);
        tv = dec_val(m_term);
        n_checks++;
        if (count !== to_bcd(m_cnt)) begin
            n_fail++;
            $display("FAIL %s count: actual=%h expected=%h", tag, count, to_bcd(m_cnt));
        end
        // R11 flags
        check_bit("zero_flag", zero_flag, m_cnt == 0);
        check_bit("warn_flag", warn_flag, m_cnt == wv);
        check_bit("term_flag", term_flag, m_cnt == tv);
    endtask

    task automatic write_raw(input logic [1:0] s, input logic [2:0] i, input logic [3:0] v);
        wr = 1; sel = s; idx = i; dat = v;
        cyc();
        wr = 0;
    endtask

    task automatic write_word(input logic [1:0] s, input int value);
        for (int d = 0; d < 6; d++) begin
            write_raw(s, 3'(d), 4'(value % 10));
            value = value / 10;
        end
    endtask

    task automatic idle();
        en = 0; hold = 0; clr = 0; ld = 0; nac = 0; nal = 0; wr = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1 reset state
        tag = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // R9 fill registers: terminal 15, warning 10, start 123
        tag = "R9";
        write_word(2'b10, 15);
        write_word(2'b01, 10);
        write_word(2'b11, 123);

        // R7 fold at terminal value
        tag = "R7";
        up = 1; en = 1;
        repeat (40) cyc();
        nac = 1;
        repeat (6) cyc();
        nac = 0;

        // R6 load outranks hold and step
        tag = "R6";
        ld = 1; hold = 1; cyc();
        ld = 0; cyc();

        // R4 hold and idle enable, also hold over a pending fold
        tag = "R4";
        hold = 1; repeat (4) cyc();
        hold = 0; en = 0; repeat (3) cyc();
        write_word(2'b10, 123);
        en = 1; hold = 1; repeat (2) cyc();
        hold = 0; cyc();

        // R2 multi-digit carry and full wrap
        tag = "R2";
        en = 0;
        write_word(2'b11, 999990);
        ld = 1; cyc(); ld = 0;
        en = 1; up = 1; nac = 1;
        repeat (14) cyc();
        en = 0;
        write_word(2'b11, 9998);
        ld = 1; cyc(); ld = 0;
        en = 1;
        repeat (4) begin cyc(); en = ~en; cyc(); en = ~en; end
        nac = 0;

        // R3 down with borrows across digits
        tag = "R3";
        en = 0;
        write_word(2'b11, 100002);
        ld = 1; cyc(); ld = 0;
        en = 1; up = 0;
        repeat (6) cyc();

        // R8 reload at zero, then suppressed
        tag = "R8";
        en = 0;
        write_word(2'b11, 5);
        ld = 1; cyc(); ld = 0;
        en = 1; up = 0;
        repeat (14) cyc();
        nal = 1;
        repeat (8) cyc();
        nal = 0;

        // R5 clear outranks everything
        tag = "R5";
        clr = 1; ld = 1; hold = 1; cyc();
        hold = 0; ld = 0; repeat (2) cyc();
        clr = 0;

        // R10 rejected writes, observed through a load
        tag = "R10";
        idle();
        for (int v = 10; v < 16; v++) write_raw(2'b11, 3'd0, 4'(v));
        write_raw(2'b11, 3'd6, 4'd7);
        write_raw(2'b11, 3'd7, 4'd7);
        write_raw(2'b00, 3'd1, 4'd7);
        ld = 1; cyc(); ld = 0; cyc();

        // R1 reset in mid-run clears registers too
        tag = "R1";
        en = 1; up = 1; repeat (3) cyc();
        rst_n = 0; repeat (2) cyc(); rst_n = 1;
        en = 0; ld = 1; cyc(); ld = 0; cyc();

        // R11 mixed pseudo-random traffic
        tag = "R11";
        write_word(2'b10, 40);
        write_word(2'b01, 20);
        write_word(2'b11, 30);
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en   = lfsr[0] | lfsr[1];
            up   = lfsr[2] | lfsr[9];
            hold = (lfsr[5:3] == 3'b111);
            clr  = (lfsr[10:6] == 5'b10101);
            ld   = (lfsr[12:8] == 5'b01100);
            nac  = (lfsr[13] & lfsr[14]);
            nal  = (lfsr[15] & lfsr[3]);
            wr   = (lfsr[7:5] == 3'b010);
            sel  = lfsr[11:10];
            idx  = 3'(lfsr[14:12] % 6);
            dat  = 4'(lfsr[4:1] % 10);
            cyc();
        end
        idle();
        cyc();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule